// File: doc/BRIEF.md
# SPI Slave Front-End with Hold Pause

This block is the serial front end of a memory-style SPI slave. It sits between the four slave-side pins and a command core. A fast system clock oversamples the pins: chip select, serial clock, serial data in and an active-low pause input. The block turns them into received bytes with a one-cycle strobe. It loads transmit bytes from the core and drives a serial output together with its own output enable, so the output can be tri-stated at the pad.

The block is selected only by a chip-select falling edge that follows a seen-high chip select. A select line that is already low when reset is released therefore never opens a transfer. Pulling the pause input low while the serial clock is low freezes the transfer in place. The output goes high impedance, and serial clock and data activity is ignored. Releasing the pause while the clock is low resumes the transfer at the same bit. Raising chip select during a pause abandons the transfer and clears all state. A mode output tells the core whether the device is active or may drop to standby. While the core reports a write cycle in progress, the mode output stays active even when the device is deselected.

Transfers use SPI mode 0, most significant bit first. Input bits are captured on serial-clock rising edges and output bits advance on falling edges. The serial clock may run at up to one quarter of the system clock rate.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, a chip select held low selects nothing. Selection starts only on a falling edge that follows chip select having been seen high.
- R2: While selected and not paused, `active_o` and `miso_oe_o` are both 1.
- R3: While deselected, `active_o` equals `busy_i`: it is 0 (standby) with busy low and 1 with busy high.
- R4: Data in is sampled on serial-clock rising edges, MSB first. After every eighth bit, `rx_valid_o` pulses for one clock with the assembled byte on `rx_byte_o`.
- R5: At selection the block loads `tx_byte_i` and pulses `tx_load_o`, and `miso_o` presents bit 7. Each falling edge shifts to the next lower bit. The falling edge after an eighth bit loads a fresh `tx_byte_i` and pulses `tx_load_o` again.
- R6: While selected, `hold_n_i` low with the serial clock low starts a pause. During the pause `miso_oe_o` is 0 and serial clock and data activity is ignored. `hold_n_i` high with the serial clock low ends the pause, and the transfer resumes at the same bit for both directions.
- R7: A change of `hold_n_i` while the serial clock is high takes effect only at the next serial-clock falling edge. The pause state is unchanged until then.
- R8: A pause request while deselected is ignored. A later selection with `hold_n_i` high transfers normally.
- R9: A chip-select rise during a pause clears the bit position, both shift registers and the pause. The next selection starts a fresh byte.
- R10: While deselected, `miso_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous, at most clk/4 |
| mosi_i | input | 1 | Serial data in, asynchronous |
| hold_n_i | input | 1 | Pause request, active low, asynchronous |
| busy_i | input | 1 | Core write cycle in progress, synchronous to clk |
| tx_byte_i | input | DATA_W | Next byte to transmit, taken when `tx_load_o` pulses |
| tx_load_o | output | 1 | One-cycle pulse: `tx_byte_i` was taken into the transmit shifter |
| rx_byte_o | output | DATA_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe: `rx_byte_o` has been updated |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the serial data out pad |
| active_o | output | 1 | 1 = active mode, 0 = standby mode |

## Verification
Two-byte transfers with complementary and mixed bit patterns in each direction show that MSB-first order, the rising and falling edge roles, and the reload between bytes are all right. A pause opened with the clock low, with clock and data toggling inside it, tells a true freeze apart from a counter that keeps running or restarts. A pause requested and released with the clock high tells clock-level qualification apart from plain level sensing. A select line held low out of reset, and a select rise during a pause, separate edge arming and full state clearing from simple level decoding.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  // link state of the serial front end
  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_XFER = 2'd1,
    FE_HOLD = 2'd2
  } fe_state_e;

  // bit positions inside the synchronized pin vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_DIN  = 2;
  localparam int PIN_HOLD = 3;
  localparam int PIN_NUM  = 4;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  input  logic busy_i,
  output logic start_o,
  output logic clear_o,
  output logic rise_o,
  output logic fall_o,
  output logic selected_o,
  output logic held_o,
  output logic active_o
);
  fe_state_e state_q, state_d;
  logic      cs_d_q, sck_d_q;
  logic      cs_fall, sck_rise, sck_fall;

  // cs history resets low: a select line low out of reset shows no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FE_IDLE;
      cs_d_q  <= 1'b0;
      sck_d_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_d_q  <= cs_n_s;
      sck_d_q <= sck_s;
    end
  end

  assign cs_fall  = cs_d_q & ~cs_n_s;
  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FE_IDLE: if (cs_fall) state_d = FE_XFER;
      FE_XFER: begin
        if (cs_n_s)                     state_d = FE_IDLE;
        else if (!hold_n_s && !sck_s)   state_d = FE_HOLD;
      end
      FE_HOLD: begin
        if (cs_n_s)                     state_d = FE_IDLE;
        else if (hold_n_s && !sck_s)    state_d = FE_XFER;
      end
      default:                          state_d = FE_IDLE;
    endcase
  end

  assign start_o    = (state_q == FE_IDLE) & cs_fall;
  assign clear_o    = cs_n_s;
  assign rise_o     = (state_q == FE_XFER) & ~cs_n_s & sck_rise;
  assign fall_o     = (state_q == FE_XFER) & ~cs_n_s & sck_fall;
  assign selected_o = (state_q != FE_IDLE);
  assign held_o     = (state_q == FE_HOLD);
  assign active_o   = selected_o | busy_i;

  // selection needs a seen-high select followed by a low one
  assert_sel_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> ($past(cs_d_q) && !$past(cs_n_s)));

  // a pause opens only with the serial clock low
  assert_hold_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> (!$past(sck_s) && !$past(hold_n_s)));

  // a pause closes by release with clock low, or by deselection (R9)
  assert_hold_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_o) |-> ($past(cs_n_s) || ($past(hold_n_s) && !$past(sck_s))));

  // no serial edge is acted on during a pause
  assert_hold_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    held_o |-> !(rise_o || fall_o));
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              hold_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              tx_load_o,
  output logic              dout_o
);
  localparam int               CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_sh_q, rx_sh_d, tx_sh_q, tx_sh_d, rx_byte_q, rx_byte_d;
  logic [DATA_W-1:0] rx_next;
  logic              rx_valid_q, rx_valid_d, tx_load_q, tx_load_d;

  assign rx_next = {rx_sh_q[DATA_W-2:0], din_i};

  always_comb begin
    cnt_d      = cnt_q;
    rx_sh_d    = rx_sh_q;
    tx_sh_d    = tx_sh_q;
    rx_byte_d  = rx_byte_q;
    rx_valid_d = 1'b0;
    tx_load_d  = 1'b0;
    if (clear_i) begin
      cnt_d   = '0;
      rx_sh_d = '0;
      tx_sh_d = '0;
    end else if (start_i) begin
      cnt_d     = '0;
      tx_sh_d   = tx_byte_i;
      tx_load_d = 1'b1;
    end else begin
      if (rise_i) begin
        rx_sh_d = rx_next;
        if (cnt_q == LAST) begin
          cnt_d      = '0;
          rx_byte_d  = rx_next;
          rx_valid_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (fall_i) begin
        if (cnt_q == '0) begin
          tx_sh_d   = tx_byte_i;
          tx_load_d = 1'b1;
        end else begin
          tx_sh_d = {tx_sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      rx_byte_q  <= '0;
      rx_valid_q <= 1'b0;
      tx_load_q  <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      rx_sh_q    <= rx_sh_d;
      tx_sh_q    <= tx_sh_d;
      rx_byte_q  <= rx_byte_d;
      rx_valid_q <= rx_valid_d;
      tx_load_q  <= tx_load_d;
    end
  end

  assign rx_byte_o  = rx_byte_q;
  assign rx_valid_o = rx_valid_q;
  assign tx_load_o  = tx_load_q;
  assign dout_o     = tx_sh_q[DATA_W-1];

  // bit position and both shifters are frozen across a pause
  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clear_i) |=> ($stable(cnt_q) && $stable(rx_sh_q) && $stable(tx_sh_q)));

  // deselection wipes the transfer state
  assert_clear_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0 && rx_sh_q == '0 && tx_sh_q == '0));
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_fe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              active_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [PIN_NUM-1:0] pins_raw, pins_s;
  logic               start, clear, rise, fall, selected, held;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n_i;
    pins_raw[PIN_SCK]  = sck_i;
    pins_raw[PIN_DIN]  = mosi_i;
    pins_raw[PIN_HOLD] = hold_n_i;
  end

  spi_fe_sync #(.W(PIN_NUM), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (pins_raw),
    .dout (pins_s)
  );

  spi_fe_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_n_s    (pins_s[PIN_CS]),
    .sck_s     (pins_s[PIN_SCK]),
    .hold_n_s  (pins_s[PIN_HOLD]),
    .busy_i    (busy_i),
    .start_o   (start),
    .clear_o   (clear),
    .rise_o    (rise),
    .fall_o    (fall),
    .selected_o(selected),
    .held_o    (held),
    .active_o  (active_o)
  );

  spi_fe_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .clear_i   (clear),
    .rise_i    (rise),
    .fall_i    (fall),
    .hold_i    (held),
    .din_i     (pins_s[PIN_DIN]),
    .tx_byte_i (tx_byte_i),
    .rx_byte_o (rx_byte_o),
    .rx_valid_o(rx_valid_o),
    .tx_load_o (tx_load_o),
    .dout_o    (miso_o)
  );

  assign miso_oe_o = selected & ~held;

  // output drive implies active mode
  assert_oe_active_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    miso_oe_o |-> active_o);

  // standby only when the core is idle
  assert_standby_busy_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !active_o |-> (!busy_i && !miso_oe_o));

  // a settled high select means no drive
  assert_desel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(pins_s[PIN_CS]) && pins_s[PIN_CS]) |-> !miso_oe_o);
endmodule

// File: tb/sim_spi_hold_frontend.sv
module sim_spi_hold_frontend;
  localparam int CLK_P = 10;
  localparam int H     = 6;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n, cs_n, sck, mosi, hold_n, busy;
  logic [DW-1:0] tx_byte, rx_byte;
  logic          tx_load, rx_valid, miso, miso_oe, active;

  int checks = 0;
  int failures = 0;
  int rx_cnt = 0;
  int ld_cnt = 0;
  logic [DW-1:0] rx_last = '0;

  always #(CLK_P/2) clk = ~clk;

  spi_hold_frontend #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_n_i(hold_n), .busy_i(busy), .tx_byte_i(tx_byte), .tx_load_o(tx_load),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .miso_o(miso),
    .miso_oe_o(miso_oe), .active_o(active)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_byte;
    end
    if (tx_load) ld_cnt <= ld_cnt + 1;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_counts();
    wait_clk(1);
    rx_cnt = 0;
    ld_cnt = 0;
  endtask

  task automatic send_bit(input logic b, output logic m);
    mosi = b;
    wait_clk(H);
    m = miso;
    sck = 1'b1;
    wait_clk(H);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [DW-1:0] mo, output logic [DW-1:0] mi);
    for (int i = DW - 1; i >= 0; i--) begin
      logic m;
      send_bit(mo[i], m);
      mi[i] = m;
    end
  endtask

  task automatic select_dev();
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic deselect_dev();
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(H);
  endtask

  // R1: select line low out of reset
  task automatic t_power_up();
    logic [DW-1:0] mi;
    chk(active == 1'b0, "R1 reset active", active, 0);
    chk(miso_oe == 1'b0, "R1 reset oe", miso_oe, 0);
    send_byte(8'hFF, mi);
    wait_clk(H);
    chk(rx_cnt == 0, "R1 no rx while unarmed", rx_cnt, 0);
    chk(ld_cnt == 0, "R1 no load while unarmed", ld_cnt, 0);
    cs_n = 1'b1;
    wait_clk(H);
    chk(active == 1'b0, "R3 standby after high", active, 0);
    select_dev();
    chk(miso_oe == 1'b1, "R1 armed select oe", miso_oe, 1);
    chk(active == 1'b1, "R2 selected active", active, 1);
    deselect_dev();
  endtask

  // R3, R10: mode reporting while deselected
  task automatic t_mode();
    busy = 1'b0;
    wait_clk(2);
    chk(active == 1'b0, "R3 standby busy low", active, 0);
    busy = 1'b1;
    wait_clk(2);
    chk(active == 1'b1, "R3 active busy high", active, 1);
    chk(miso_oe == 1'b0, "R10 deselected oe", miso_oe, 0);
    busy = 1'b0;
    wait_clk(2);
  endtask

  // R4, R5: two-byte transfers
  task automatic t_xfer(input logic [DW-1:0] o1, input logic [DW-1:0] o2,
                        input logic [DW-1:0] t1, input logic [DW-1:0] t2,
                        input logic [DW-1:0] t3);
    logic [DW-1:0] mi;
    clr_counts();
    tx_byte = t1;
    select_dev();
    tx_byte = t2;
    send_byte(o1, mi);
    chk(mi == t1, "R5 first tx byte", mi, t1);
    wait_clk(H);
    chk(rx_last == o1, "R4 first rx byte", rx_last, o1);
    tx_byte = t3;
    send_byte(o2, mi);
    chk(mi == t2, "R5 reloaded tx byte", mi, t2);
    wait_clk(H);
    chk(rx_last == o2, "R4 second rx byte", rx_last, o2);
    chk(rx_cnt == 2, "R4 strobe count", rx_cnt, 2);
    chk(ld_cnt == 3, "R5 load count", ld_cnt, 3);
    deselect_dev();
  endtask

  // R6: pause with clock low, activity inside ignored
  task automatic t_hold_low();
    logic [DW-1:0] mi;
    logic [DW-1:0] mo;
    logic m;
    mo = 8'hB4;
    clr_counts();
    tx_byte = 8'h96;
    select_dev();
    for (int i = DW - 1; i >= 5; i--) begin
      send_bit(mo[i], m);
      mi[i] = m;
    end
    hold_n = 1'b0;
    wait_clk(H);
    chk(miso_oe == 1'b0, "R6 pause oe off", miso_oe, 0);
    for (int k = 0; k < 4; k++) begin
      mosi = k[0];
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
      wait_clk(H);
    end
    chk(rx_cnt == 0, "R6 no strobe in pause", rx_cnt, 0);
    hold_n = 1'b1;
    wait_clk(H);
    chk(miso_oe == 1'b1, "R6 pause released oe", miso_oe, 1);
    for (int i = 4; i >= 0; i--) begin
      send_bit(mo[i], m);
      mi[i] = m;
    end
    wait_clk(H);
    chk(rx_last == mo, "R6 rx resumes same bit", rx_last, mo);
    chk(rx_cnt == 1, "R6 one strobe", rx_cnt, 1);
    chk(mi == 8'h96, "R6 tx resumes same bit", mi, 8'h96);
    deselect_dev();
  endtask

  // R7: pause requests while clock is high
  task automatic t_hold_high();
    logic [DW-1:0] mi;
    logic [DW-1:0] mo;
    mo = 8'h6D;
    clr_counts();
    tx_byte = 8'h2B;
    select_dev();
    mosi = mo[7];
    wait_clk(H);
    mi[7] = miso;
    sck = 1'b1;
    wait_clk(H);
    hold_n = 1'b0;
    wait_clk(H);
    chk(miso_oe == 1'b1, "R7 no entry with clock high", miso_oe, 1);
    sck = 1'b0;
    wait_clk(H);
    chk(miso_oe == 1'b0, "R7 entry at falling edge", miso_oe, 0);
    sck = 1'b1;
    wait_clk(H);
    hold_n = 1'b1;
    wait_clk(H);
    chk(miso_oe == 1'b0, "R7 no exit with clock high", miso_oe, 0);
    sck = 1'b0;
    wait_clk(H);
    chk(miso_oe == 1'b1, "R7 exit at falling edge", miso_oe, 1);
    for (int i = DW - 2; i >= 0; i--) begin
      logic m;
      send_bit(mo[i], m);
      mi[i] = m;
    end
    wait_clk(H);
    chk(rx_last == mo, "R7 rx intact", rx_last, mo);
    chk(rx_cnt == 1, "R7 one strobe", rx_cnt, 1);
    chk(mi == 8'h2B, "R7 tx intact", mi, 8'h2B);
    deselect_dev();
  endtask

  // R8: pause request while deselected
  task automatic t_hold_desel();
    logic [DW-1:0] mi;
    clr_counts();
    hold_n = 1'b0;
    wait_clk(H);
    chk(miso_oe == 1'b0, "R8 deselected oe", miso_oe, 0);
    chk(active == 1'b0, "R8 still standby", active, 0);
    hold_n = 1'b1;
    wait_clk(H);
    tx_byte = 8'hE1;
    select_dev();
    chk(miso_oe == 1'b1, "R8 select drives", miso_oe, 1);
    send_byte(8'h3C, mi);
    wait_clk(H);
    chk(rx_last == 8'h3C, "R8 normal rx", rx_last, 8'h3C);
    chk(mi == 8'hE1, "R8 normal tx", mi, 8'hE1);
    deselect_dev();
  endtask

  // R9: select rise during pause
  task automatic t_hold_abort();
    logic [DW-1:0] mi;
    logic m;
    clr_counts();
    tx_byte = 8'hF0;
    select_dev();
    for (int i = 0; i < 3; i++) send_bit(1'b1, m);
    hold_n = 1'b0;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(H);
    chk(miso_oe == 1'b0, "R9 abort oe", miso_oe, 0);
    hold_n = 1'b1;
    wait_clk(H);
    tx_byte = 8'h81;
    select_dev();
    chk(miso_oe == 1'b1, "R9 pause cleared", miso_oe, 1);
    send_byte(8'h42, mi);
    wait_clk(H);
    chk(rx_cnt == 1, "R9 one strobe", rx_cnt, 1);
    chk(rx_last == 8'h42, "R9 fresh rx byte", rx_last, 8'h42);
    chk(mi == 8'h81, "R9 fresh tx byte", mi, 8'h81);
    deselect_dev();
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b0;
    sck = 1'b0;
    mosi = 1'b0;
    hold_n = 1'b1;
    busy = 1'b0;
    tx_byte = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    t_power_up();
    t_mode();
    t_xfer(8'hA5, 8'h5A, 8'hC3, 8'h3C, 8'h0F);
    t_xfer(8'h00, 8'hFF, 8'hFF, 8'h00, 8'h81);
    t_hold_low();
    t_hold_high();
    t_hold_desel();
    t_hold_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule